// File: doc/BRIEF.md
# DMA Channel Address and Count Sequencer

This block holds the per-channel transfer state of a multi-channel DMA engine. Each channel keeps base and current copies of a 16-bit address and a 16-bit count, plus a page value, a mode and a byte/word width flag. Writing a channel's configuration loads both the base and current copies and arms the channel. A configuration write is accepted only when `cfg_we` is high; the channel is picked by `cfg_ch`.

On each granted transfer strobe for an armed channel, the block does three things:
- It emits the 24-bit physical address of that transfer, together with a valid flag, a terminal-count flag and a direction flag.
- It steps the current address.
- It decrements the current count.

The page is never touched by the address counter. A run therefore wraps inside its 64K (byte) or 128K (word) window.

Arbitration between channels and the bus cycles themselves are done elsewhere. A remaining-transfer figure for any channel can be read back through `rd_ch`.

Top module: `dmaseq_top`

## Requirements
- R1: While `rst` is high (synchronous), every channel becomes masked (`chan_masked` all ones). `addr_vld` and `tc` are cleared.
- R2: A byte channel (`cfg_word`=0) emits `phys_addr` = {page[7:0], cur_addr[15:0]}. The result appears one clock after the strobe edge.
- R3: A word channel emits {page[7:1], cur_addr[15:0], 1'b0}. Page bit 0 is ignored, and successive transfers advance the byte address by 2.
- R4: The page never changes during a run, so the address wraps from 0xFFFF to 0x0000 within the same 64K or 128K window.
- R5: A programmed count C yields exactly C+1 accepted transfers. `tc` is high only on the last one, which is the transfer made with current count 0x0000.
- R6: The current address increments by 1 per transfer. It decrements instead when mode bit 5 (0x20) is set.
- R7: Without autoinitialize, a channel masks itself after its terminal-count transfer. Later strobes to it give `addr_vld`=0.
- R8: With mode bit 4 (0x10) set, the terminal-count transfer reloads the current address and count from the base values. The channel stays armed.
- R9: A channel whose mode bits [7:6] are 2'b11 (cascade) never produces an address. A strobe to it leaves `addr_vld` at 0 and its count unchanged.
- R10: `to_mem` is 1 for transfers of a channel with mode bits [3:2]=2'b01 (I/O to memory). It is 0 for 2'b10 (memory to I/O).
- R11: `residue` shows (current count + 1) mod 2^16 of channel `rd_ch`, one clock after selection. It reads 0 after a completed run.
- R12: A configuration write arms the channel (clears its mask bit) and loads the current values from the new base. Strobes to one channel leave every other channel's state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 2 | Channel being configured |
| cfg_addr | input | 16 | Base address value |
| cfg_cnt | input | 16 | Base count, transfers minus one |
| cfg_page | input | 8 | Page value |
| cfg_mode | input | 6 | Mode bits [7:2]: cascade [7:6], decrement [5], autoinit [4], direction [3:2] |
| cfg_word | input | 1 | 1 = word channel, 0 = byte channel |
| xfer_stb | input | 1 | Granted transfer strobe |
| xfer_ch | input | 2 | Channel of the granted transfer |
| rd_ch | input | 2 | Channel whose residue is shown |
| phys_addr | output | 24 | Physical byte address of the transfer |
| addr_vld | output | 1 | phys_addr is valid this cycle |
| tc | output | 1 | Terminal-count transfer |
| to_mem | output | 1 | Transfer direction, 1 = I/O to memory |
| residue | output | 16 | Remaining transfers of channel rd_ch |
| chan_masked | output | 4 | Mask state per channel |

## Verification
The bench builds the block with its defaults: four channels, a 16-bit address and count, and an 8-bit page. Four channels let a byte run, a word run, an autoinitializing channel and a cascade channel be configured together, so the bench can show that strobes to one leave the others' residues untouched. The counter width places the wrap at 0xFFFF. Preloading addresses near that edge brings the 64K and 128K window wrap, in both directions, within a few transfers.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

  typedef struct packed {
    logic cascade;
    logic dec;
    logic autoinit;
    logic to_mem;
  } mode_t;

  function automatic mode_t decode_mode(input logic [7:2] m);
    mode_t r;
    r.cascade  = (m[7:6] == 2'b11);
    r.dec      = m[5];
    r.autoinit = m[4];
    r.to_mem   = (m[3:2] == 2'b01);
    return r;
  endfunction

endpackage

// File: rtl/dmaseq_addr_map.sv
module dmaseq_addr_map #(
  parameter int AW = 16,
  parameter int PW = 8,
  localparam int PAW = AW + PW
) (
  input  logic          word,
  input  logic [PW-1:0] page,
  input  logic [AW-1:0] addr,
  output logic [PAW-1:0] phys
);
  always_comb begin
    if (word) phys = {page[PW-1:1], addr, 1'b0};
    else      phys = {page, addr};
  end
endmodule

// File: rtl/dmaseq_chan.sv
module dmaseq_chan
  import dmaseq_pkg::*;
#(
  parameter int AW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic [AW-1:0] ld_cnt,
  input  logic [PW-1:0] ld_page,
  input  mode_t         ld_mode,
  input  logic          ld_word,
  input  logic          step,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] cur_cnt,
  output logic [PW-1:0] page_q,
  output mode_t         mode_q,
  output logic          word_q,
  output logic          masked,
  output logic          accept
);
  logic [AW-1:0] base_addr, base_cnt, nxt_addr;
  logic          last;

  assign accept   = step && !masked && !mode_q.cascade;
  assign last     = (cur_cnt == '0);
  assign nxt_addr = mode_q.dec ? cur_addr - AW'(1) : cur_addr + AW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
      page_q    <= '0;
      mode_q    <= '0;
      word_q    <= 1'b0;
      masked    <= 1'b1;
    end else if (load) begin
      base_addr <= ld_addr;
      base_cnt  <= ld_cnt;
      cur_addr  <= ld_addr;
      cur_cnt   <= ld_cnt;
      page_q    <= ld_page;
      mode_q    <= ld_mode;
      word_q    <= ld_word;
      masked    <= 1'b0;
    end else if (accept) begin
      if (last && mode_q.autoinit) begin
        cur_addr <= base_addr;
        cur_cnt  <= base_cnt;
      end else begin
        cur_addr <= nxt_addr;
        cur_cnt  <= cur_cnt - AW'(1);
        if (last) masked <= 1'b1;
      end
    end
  end

  assert_self_mask_R7: assert property (@(posedge clk) disable iff (rst)
    (accept && !load && last && !mode_q.autoinit) |=> masked);

  assert_reload_R8: assert property (@(posedge clk) disable iff (rst)
    (accept && !load && last && mode_q.autoinit) |=> (!masked && cur_cnt == $past(base_cnt)));

  assert_cnt_step_R5: assert property (@(posedge clk) disable iff (rst)
    (accept && !load && !last) |=> (cur_cnt == $past(cur_cnt) - AW'(1)));

  assert_page_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (accept && !load) |=> $stable(page_q));

  assert_cascade_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (step && !load && mode_q.cascade) |=> $stable(cur_cnt));
endmodule

// File: rtl/dmaseq_top.sv
module dmaseq_top
  import dmaseq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int PW  = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int PAW = AW + PW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [CHW-1:0]  cfg_ch,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [AW-1:0]   cfg_cnt,
  input  logic [PW-1:0]   cfg_page,
  input  logic [7:2]      cfg_mode,
  input  logic            cfg_word,
  input  logic            xfer_stb,
  input  logic [CHW-1:0]  xfer_ch,
  input  logic [CHW-1:0]  rd_ch,
  output logic [PAW-1:0]  phys_addr,
  output logic            addr_vld,
  output logic            tc,
  output logic            to_mem,
  output logic [AW-1:0]   residue,
  output logic [NCH-1:0]  chan_masked
);
  mode_t         cfg_dec;
  logic [AW-1:0] c_addr [NCH];
  logic [AW-1:0] c_cnt  [NCH];
  logic [PW-1:0] c_page [NCH];
  mode_t         c_mode [NCH];
  logic          c_word [NCH];
  logic [NCH-1:0] c_acc;
  logic [PAW-1:0] sel_phys;

  assign cfg_dec = decode_mode(cfg_mode);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic ld, st;
    assign ld = cfg_we && (cfg_ch == CHW'(i));
    assign st = xfer_stb && (xfer_ch == CHW'(i)) && !ld;
    dmaseq_chan #(.AW(AW), .PW(PW)) u_chan (
      .clk(clk), .rst(rst), .load(ld),
      .ld_addr(cfg_addr), .ld_cnt(cfg_cnt), .ld_page(cfg_page),
      .ld_mode(cfg_dec), .ld_word(cfg_word), .step(st),
      .cur_addr(c_addr[i]), .cur_cnt(c_cnt[i]), .page_q(c_page[i]),
      .mode_q(c_mode[i]), .word_q(c_word[i]), .masked(chan_masked[i]),
      .accept(c_acc[i])
    );
  end

  dmaseq_addr_map #(.AW(AW), .PW(PW)) u_map (
    .word(c_word[xfer_ch]), .page(c_page[xfer_ch]),
    .addr(c_addr[xfer_ch]), .phys(sel_phys)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phys_addr <= '0;
      addr_vld  <= 1'b0;
      tc        <= 1'b0;
      to_mem    <= 1'b0;
      residue   <= '0;
    end else begin
      addr_vld <= |c_acc;
      tc       <= (|c_acc) && (c_cnt[xfer_ch] == '0);
      if (|c_acc) begin
        phys_addr <= sel_phys;
        to_mem    <= c_mode[xfer_ch].to_mem;
      end
      residue <= c_cnt[rd_ch] + AW'(1);
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!addr_vld && !tc && (&chan_masked)));

  assert_tc_has_addr_R5: assert property (@(posedge clk) disable iff (rst)
    tc |-> addr_vld);

  assert_cascade_silent_R9: assert property (@(posedge clk) disable iff (rst)
    (xfer_stb && !cfg_we && c_mode[xfer_ch].cascade) |=> !addr_vld);

  assert_masked_silent_R7: assert property (@(posedge clk) disable iff (rst)
    (xfer_stb && !cfg_we && chan_masked[xfer_ch]) |=> !addr_vld);
endmodule

// File: tb/dmaseq_top_test.sv
module dmaseq_top_test;
  logic clk = 0, rst = 1;
  logic cfg_we = 0, cfg_word = 0, xfer_stb = 0;
  logic [1:0] cfg_ch = 0, xfer_ch = 0, rd_ch = 0;
  logic [15:0] cfg_addr = 0, cfg_cnt = 0;
  logic [7:0] cfg_page = 0;
  logic [7:2] cfg_mode = 0;
  logic [23:0] phys_addr;
  logic addr_vld, tc, to_mem;
  logic [15:0] residue;
  logic [3:0] chan_masked;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  dmaseq_top uut (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] expect_phys(input bit w, input logic [7:0] p, input logic [15:0] a);
    logic [23:0] r;
    if (w) r = ({16'h0, p} >> 1) * 24'h20000 + {8'h0, a} * 2;
    else   r = {16'h0, p} * 24'h10000 + {8'h0, a};
    return r;
  endfunction

  task automatic configure(input int ch, input logic [15:0] a, input logic [15:0] c,
                           input logic [7:0] p, input logic [7:0] m, input bit w);
    cfg_ch = 2'(ch); cfg_addr = a; cfg_cnt = c; cfg_page = p; cfg_mode = m[7:2]; cfg_word = w;
    cfg_we = 1;
    @(posedge clk); @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic strobe(input int ch);
    xfer_ch = 2'(ch); xfer_stb = 1;
    @(posedge clk); @(negedge clk);
    xfer_stb = 0;
  endtask

  task automatic step_chk(input int ch, input bit w, input logic [7:0] p, input logic [15:0] a,
                          input bit exp_tc, input string tag);
    logic [23:0] e;
    strobe(ch);
    e = expect_phys(w, p, a);
    chk(addr_vld === 1'b1, {tag, " vld"}, addr_vld, 1);
    chk(phys_addr === e, {tag, " addr"}, phys_addr, e);
    chk(tc === exp_tc, {tag, " tc"}, tc, exp_tc);
  endtask

  task automatic res_chk(input int ch, input logic [15:0] e, input string tag);
    rd_ch = 2'(ch);
    @(posedge clk); @(negedge clk);
    chk(residue === e, tag, residue, e);
  endtask

  task automatic t_reset();
    chk(chan_masked === 4'hF, "R1 masks", chan_masked, 4'hF);
    chk(addr_vld === 0 && tc === 0, "R1 vld/tc", {addr_vld, tc}, 0);
  endtask

  task automatic t_byte_wrap();
    configure(0, 16'hFFFE, 16'd3, 8'h5A, 8'h44, 0);
    chk(chan_masked[0] === 0, "R12 armed", chan_masked[0], 0);
    res_chk(0, 16'd4, "R11 residue fresh");
    step_chk(0, 0, 8'h5A, 16'hFFFE, 0, "R2 first");
    chk(to_mem === 1, "R10 to_mem", to_mem, 1);
    step_chk(0, 0, 8'h5A, 16'hFFFF, 0, "R2 second");
    step_chk(0, 0, 8'h5A, 16'h0000, 0, "R4 wrap");
    step_chk(0, 0, 8'h5A, 16'h0001, 1, "R5 last");
    res_chk(0, 16'd0, "R11 residue done");
    chk(chan_masked[0] === 1, "R7 self mask", chan_masked[0], 1);
    strobe(0);
    chk(addr_vld === 0, "R7 ignored", addr_vld, 0);
  endtask

  task automatic t_rearm();
    configure(0, 16'h0100, 16'd0, 8'h01, 8'h44, 0);
    chk(chan_masked[0] === 0, "R12 rearm", chan_masked[0], 0);
    step_chk(0, 0, 8'h01, 16'h0100, 1, "R5 single");
  endtask

  task automatic t_decrement();
    configure(1, 16'h0001, 16'd2, 8'h10, 8'h64, 0);
    step_chk(1, 0, 8'h10, 16'h0001, 0, "R6 dec1");
    step_chk(1, 0, 8'h10, 16'h0000, 0, "R6 dec2");
    step_chk(1, 0, 8'h10, 16'hFFFF, 1, "R6 dec wrap R4");
  endtask

  task automatic t_word();
    configure(2, 16'hFFFF, 16'd1, 8'h13, 8'h48, 1);
    step_chk(2, 1, 8'h13, 16'hFFFF, 0, "R3 word");
    chk(to_mem === 0, "R10 from_mem", to_mem, 0);
    chk(phys_addr === 24'h13FFFE, "R3 literal", phys_addr, 24'h13FFFE);
    step_chk(2, 1, 8'h13, 16'h0000, 1, "R3 word wrap R4");
    chk(phys_addr === 24'h120000, "R3 window", phys_addr, 24'h120000);
  endtask

  task automatic t_autoinit();
    configure(3, 16'h1000, 16'd1, 8'h02, 8'h54, 0);
    step_chk(3, 0, 8'h02, 16'h1000, 0, "R8 a");
    step_chk(3, 0, 8'h02, 16'h1001, 1, "R8 b");
    chk(chan_masked[3] === 0, "R8 stays armed", chan_masked[3], 0);
    res_chk(3, 16'd2, "R8 count reload");
    step_chk(3, 0, 8'h02, 16'h1000, 0, "R8 addr reload");
  endtask

  task automatic t_cascade();
    configure(1, 16'h2000, 16'd5, 8'h00, 8'hC0, 0);
    strobe(1);
    chk(addr_vld === 0, "R9 no addr", addr_vld, 0);
    res_chk(1, 16'd6, "R9 count held");
  endtask

  task automatic t_isolation();
    configure(2, 16'h0000, 16'd7, 8'h00, 8'h44, 0);
    strobe(3); strobe(3);
    res_chk(2, 16'd8, "R12 isolation");
  endtask

  initial begin
    #200000000;
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    t_reset();
    rst = 0;
    @(negedge clk);
    t_byte_wrap();
    t_rearm();
    t_decrement();
    t_word();
    t_autoinit();
    t_cascade();
    t_isolation();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule